// File: doc/BRIEF.md
# OUT Endpoint DMA Channel

This channel drains received packets from the banks of an OUT endpoint into a buffer in system memory. Software sets a start address and a byte budget, then raises the run control. The channel reads one byte at a time from the endpoint's read port and presents it on a write port with a valid/ready handshake. The address advances by one and the remaining count drops by one for every byte the memory accepts.

A transfer ends in one of two ways. The first is that the byte budget is used up. The second, when short-packet termination is on, is that a packet shorter than the maximum size (including an empty one) has been fully moved. If the budget runs out inside a packet, the unmoved tail is either left in the bank for software or, in truncation mode, discarded. The endpoint releases a drained bank by itself. The channel requests an explicit release only for an empty packet or for a truncated tail. Two sticky flags record why the transfer ended, and each can raise a level interrupt. The channel then sits idle until the run control is lowered and raised again.

Top module: `dma_out_chan`

## Requirements
- R1: After reset, busy, mem_valid, ep_pop, ep_drop, both status flags and irq are 0, and remain is 0.
- R2: When cfg_run is high while the channel is idle, the channel loads cfg_addr and cfg_size and is busy from the next cycle. With a size of 0, it ends at once with sts_eob set and moves no byte.
- R3: Each byte is offered with mem_valid high and mem_data equal to ep_data. The first address is cfg_addr, and each accepted byte adds one to the address. ep_pop is high exactly in the cycles where mem_valid and mem_ready are both high. The address holds while mem_ready is low.
- R4: remain drops by one after each accepted byte. The transfer ends with sts_eob set once remain reaches 0.
- R5: With cfg_eot_en set, the transfer ends with sts_eot set after the last byte of a short packet. If that byte also empties the budget, sts_eob is set as well. With cfg_eot_en clear, short packets do not end the transfer.
- R6: An empty packet (ep_len of 0) is released with a one-cycle ep_drop. With cfg_eot_en set, it ends the transfer with sts_eot. Otherwise the channel goes on to the next packet.
- R7: When the budget ends inside a packet and cfg_trunc_en is set, ep_drop pulses for one cycle and the tail is discarded. When cfg_trunc_en is clear, the tail stays in the endpoint untouched.
- R8: After a transfer ends, busy is 0 and no byte is popped, even while packets wait and cfg_run stays high. Both flags read 0 once a new transfer has started.
- R9: irq equals (sts_eob and cfg_eob_irq_en) or (sts_eot and cfg_eot_irq_en), held as a level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_addr | input | AW | Buffer start address |
| cfg_size | input | CW | Buffer size in bytes |
| cfg_run | input | 1 | Channel run control |
| cfg_eob_irq_en | input | 1 | Interrupt enable for end of buffer |
| cfg_eot_en | input | 1 | Short packet ends the transfer |
| cfg_eot_irq_en | input | 1 | Interrupt enable for short-packet end |
| cfg_trunc_en | input | 1 | Discard packet tail that does not fit |
| ep_avail | input | 1 | A filled bank is present |
| ep_len | input | LW | Byte count of the current packet |
| ep_short | input | 1 | Current packet is shorter than the maximum size |
| ep_data | input | 8 | Byte at the endpoint read pointer |
| ep_pop | output | 1 | Consume one byte from the endpoint |
| ep_drop | output | 1 | Release the current bank, discarding what is left |
| mem_addr | output | AW | Write address |
| mem_data | output | 8 | Write data |
| mem_valid | output | 1 | Write request |
| mem_ready | input | 1 | Memory accepts the write |
| remain | output | CW | Bytes left in the buffer |
| busy | output | 1 | Transfer in progress |
| sts_eob | output | 1 | Transfer ended with the buffer full |
| sts_eot | output | 1 | Transfer ended by a short or empty packet |
| irq | output | 1 | Interrupt |

## Verification
The hardest situation to reach is a packet that straddles the end of the buffer while the memory stalls. Both the truncation request and the choice to leave the tail depend on the last accepted byte landing in the middle of a packet. The stimulus sizes the buffer so that it ends inside a full-size packet, queues further packets behind that one, and randomizes mem_ready every cycle, so the final handshake falls on varying cycles. Counting the bytes left in the endpoint model afterwards shows whether the tail was discarded, kept, or wrongly read on.

// File: rtl/dma_out_pkg.sv
package dma_out_pkg;

    typedef enum logic [2:0] {
        CH_IDLE,
        CH_WAIT,
        CH_MOVE,
        CH_TRUNC,
        CH_DONE
    } ch_state_e;

    typedef struct packed {
        logic eob;
        logic eot;
    } end_cause_t;

    // Why (if at all) the transfer stops after the byte now being accepted.
    function automatic end_cause_t byte_end_cause(
        input logic last_of_pkt,
        input logic last_of_buf,
        input logic short_pkt,
        input logic eot_en
    );
        end_cause_t c;
        c.eob = last_of_buf;
        c.eot = last_of_pkt && short_pkt && eot_en;
        return c;
    endfunction

endpackage

// File: rtl/dma_out_cnt.sv
module dma_out_cnt #(
    parameter int AW = 32,
    parameter int CW = 16,
    parameter int LW = 11
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [AW-1:0] load_addr,
    input  logic [CW-1:0] load_size,
    input  logic          pkt_load,
    input  logic [LW-1:0] pkt_len,
    input  logic          step,
    output logic [AW-1:0] addr,
    output logic [CW-1:0] remain,
    output logic [LW-1:0] pkt_left
);
    localparam logic [AW-1:0] ADDR_INC = AW'(1);
    localparam logic [CW-1:0] CNT_DEC  = CW'(1);
    localparam logic [LW-1:0] PKT_DEC  = LW'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            addr     <= '0;
            remain   <= '0;
            pkt_left <= '0;
        end else begin
            if (load) begin
                addr   <= load_addr;
                remain <= load_size;
            end else if (step) begin
                addr   <= addr + ADDR_INC;
                remain <= remain - CNT_DEC;
            end
            if (pkt_load)
                pkt_left <= pkt_len;
            else if (step)
                pkt_left <= pkt_left - PKT_DEC;
        end
    end

    // R4
    no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
        step |-> (remain != '0));

endmodule

// File: rtl/dma_out_seq.sv
module dma_out_seq
    import dma_out_pkg::*;
#(
    parameter int CW = 16,
    parameter int LW = 11
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_run,
    input  logic          cfg_eob_irq_en,
    input  logic          cfg_eot_en,
    input  logic          cfg_eot_irq_en,
    input  logic          cfg_trunc_en,
    input  logic          ep_avail,
    input  logic [LW-1:0] ep_len,
    input  logic          ep_short,
    input  logic          mem_ready,
    input  logic [CW-1:0] remain,
    input  logic [LW-1:0] pkt_left,
    output logic          load,
    output logic          pkt_load,
    output logic          step,
    output logic          ep_pop,
    output logic          ep_drop,
    output logic          mem_valid,
    output logic          busy,
    output logic          sts_eob,
    output logic          sts_eot,
    output logic          irq
);
    localparam logic [CW-1:0] LAST_BUF = CW'(1);
    localparam logic [LW-1:0] LAST_PKT = LW'(1);

    ch_state_e  state, nxt;
    logic       pkt_short_q;
    logic       set_eob, set_eot;
    end_cause_t cause;

    always_comb begin
        nxt       = state;
        load      = 1'b0;
        pkt_load  = 1'b0;
        step      = 1'b0;
        ep_drop   = 1'b0;
        mem_valid = 1'b0;
        set_eob   = 1'b0;
        set_eot   = 1'b0;
        cause     = byte_end_cause(pkt_left == LAST_PKT, remain == LAST_BUF,
                                   pkt_short_q, cfg_eot_en);
        case (state)
            CH_IDLE: if (cfg_run) begin
                load = 1'b1;
                nxt  = CH_WAIT;
            end
            CH_WAIT: begin
                if (remain == '0) begin
                    set_eob = 1'b1;
                    nxt     = CH_DONE;
                end else if (ep_avail) begin
                    if (ep_len == '0) begin
                        ep_drop = 1'b1;
                        if (cfg_eot_en) begin
                            set_eot = 1'b1;
                            nxt     = CH_DONE;
                        end
                    end else begin
                        pkt_load = 1'b1;
                        nxt      = CH_MOVE;
                    end
                end
            end
            CH_MOVE: begin
                mem_valid = 1'b1;
                if (mem_ready) begin
                    step = 1'b1;
                    if (cause.eob || cause.eot) begin
                        set_eob = cause.eob;
                        set_eot = cause.eot;
                        if (cause.eob && !cause.eot && pkt_left != LAST_PKT && cfg_trunc_en)
                            nxt = CH_TRUNC;
                        else
                            nxt = CH_DONE;
                    end else if (pkt_left == LAST_PKT) begin
                        nxt = CH_WAIT;
                    end
                end
            end
            CH_TRUNC: begin
                ep_drop = 1'b1;
                nxt     = CH_DONE;
            end
            CH_DONE: if (!cfg_run) nxt = CH_IDLE;
            default: nxt = CH_IDLE;
        endcase
    end

    assign ep_pop = step;
    assign busy   = (state == CH_WAIT) || (state == CH_MOVE) || (state == CH_TRUNC);
    assign irq    = (sts_eob && cfg_eob_irq_en) || (sts_eot && cfg_eot_irq_en);

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= CH_IDLE;
            pkt_short_q <= 1'b0;
            sts_eob     <= 1'b0;
            sts_eot     <= 1'b0;
        end else begin
            state <= nxt;
            if (pkt_load) pkt_short_q <= ep_short;
            if (load) begin
                sts_eob <= 1'b0;
                sts_eot <= 1'b0;
            end else begin
                if (set_eob) sts_eob <= 1'b1;
                if (set_eot) sts_eot <= 1'b1;
            end
        end
    end

    // R3
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && !mem_ready) |=> mem_valid);

    // R8
    idle_no_pop_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !ep_pop);

    // R7
    drop_single_chk: assert property (@(posedge clk) disable iff (rst)
        (ep_drop && state == CH_TRUNC) |=> !ep_drop);

    // R9
    irq_cause_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> (sts_eob || sts_eot));

endmodule

// File: rtl/dma_out_chan.sv
module dma_out_chan #(
    parameter int AW = 32,
    parameter int CW = 16,
    parameter int LW = 11
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] cfg_addr,
    input  logic [CW-1:0] cfg_size,
    input  logic          cfg_run,
    input  logic          cfg_eob_irq_en,
    input  logic          cfg_eot_en,
    input  logic          cfg_eot_irq_en,
    input  logic          cfg_trunc_en,
    input  logic          ep_avail,
    input  logic [LW-1:0] ep_len,
    input  logic          ep_short,
    input  logic [7:0]    ep_data,
    output logic          ep_pop,
    output logic          ep_drop,
    output logic [AW-1:0] mem_addr,
    output logic [7:0]    mem_data,
    output logic          mem_valid,
    input  logic          mem_ready,
    output logic [CW-1:0] remain,
    output logic          busy,
    output logic          sts_eob,
    output logic          sts_eot,
    output logic          irq
);
    logic          load, pkt_load, step;
    logic [LW-1:0] pkt_left;

    dma_out_cnt #(.AW(AW), .CW(CW), .LW(LW)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .load_addr (cfg_addr),
        .load_size (cfg_size),
        .pkt_load  (pkt_load),
        .pkt_len   (ep_len),
        .step      (step),
        .addr      (mem_addr),
        .remain    (remain),
        .pkt_left  (pkt_left)
    );

    dma_out_seq #(.CW(CW), .LW(LW)) u_seq (
        .clk            (clk),
        .rst            (rst),
        .cfg_run        (cfg_run),
        .cfg_eob_irq_en (cfg_eob_irq_en),
        .cfg_eot_en     (cfg_eot_en),
        .cfg_eot_irq_en (cfg_eot_irq_en),
        .cfg_trunc_en   (cfg_trunc_en),
        .ep_avail       (ep_avail),
        .ep_len         (ep_len),
        .ep_short       (ep_short),
        .mem_ready      (mem_ready),
        .remain         (remain),
        .pkt_left       (pkt_left),
        .load           (load),
        .pkt_load       (pkt_load),
        .step           (step),
        .ep_pop         (ep_pop),
        .ep_drop        (ep_drop),
        .mem_valid      (mem_valid),
        .busy           (busy),
        .sts_eob        (sts_eob),
        .sts_eot        (sts_eot),
        .irq            (irq)
    );

    assign mem_data = ep_data;

    // R3
    addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && !mem_ready) |=> $stable(mem_addr));

    // R3
    addr_step_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && mem_ready) |=> (mem_addr == $past(mem_addr) + AW'(1)));

endmodule

// File: tb/dma_out_chan_test.sv
module dma_out_chan_test;
    localparam int CLK_PERIOD = 10;
    localparam int AW  = 32;
    localparam int CW  = 16;
    localparam int LW  = 11;
    localparam int MPS = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] cfg_addr = '0;
    logic [CW-1:0] cfg_size = '0;
    logic          cfg_run = 1'b0, cfg_eob_irq_en = 1'b0, cfg_eot_en = 1'b0;
    logic          cfg_eot_irq_en = 1'b0, cfg_trunc_en = 1'b0;
    logic          ep_avail = 1'b0, ep_short = 1'b0;
    logic [LW-1:0] ep_len = '0;
    logic [7:0]    ep_data = '0;
    logic          ep_pop, ep_drop, mem_valid, busy, sts_eob, sts_eot, irq;
    logic          mem_ready = 1'b0;
    logic [AW-1:0] mem_addr;
    logic [7:0]    mem_data;
    logic [CW-1:0] remain;

    int checks = 0;
    int errors = 0;
    logic [15:0] lfsr = 16'hACE1;

    logic [7:0] ep_bytes[$];
    int         ep_lens[$];
    bit         ep_sh[$];
    logic [7:0] exp_data[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_out_chan #(.AW(AW), .CW(CW), .LW(LW)) uut (
        .clk(clk), .rst(rst), .cfg_addr(cfg_addr), .cfg_size(cfg_size),
        .cfg_run(cfg_run), .cfg_eob_irq_en(cfg_eob_irq_en), .cfg_eot_en(cfg_eot_en),
        .cfg_eot_irq_en(cfg_eot_irq_en), .cfg_trunc_en(cfg_trunc_en),
        .ep_avail(ep_avail), .ep_len(ep_len), .ep_short(ep_short), .ep_data(ep_data),
        .ep_pop(ep_pop), .ep_drop(ep_drop), .mem_addr(mem_addr), .mem_data(mem_data),
        .mem_valid(mem_valid), .mem_ready(mem_ready), .remain(remain), .busy(busy),
        .sts_eob(sts_eob), .sts_eot(sts_eot), .irq(irq)
    );

    task automatic check(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic refresh_ep();
        ep_avail = ep_lens.size() > 0;
        ep_len   = ep_avail ? LW'(ep_lens[0]) : '0;
        ep_short = ep_avail ? ep_sh[0] : 1'b0;
        ep_data  = (ep_bytes.size() > 0) ? ep_bytes[0] : 8'h00;
    endtask

    task automatic add_pkt(input int len, input int seed);
        for (int i = 0; i < len; i++) ep_bytes.push_back(8'(seed + 7 * i));
        ep_lens.push_back(len);
        ep_sh.push_back(len < MPS);
        refresh_ep();
    endtask

    task automatic clear_ep();
        ep_bytes.delete();
        ep_lens.delete();
        ep_sh.delete();
        refresh_ep();
    endtask

    task automatic run_case(input string tag, input logic [AW-1:0] base, input int size,
                            input bit eot_en, input bit trunc, input bit eobie, input bit eotie);
        int  cnt = size, idx = 0, left = ep_bytes.size(), nwr = 0, ref_remain, cyc = 0;
        bit  e_eob = 0, e_eot = 0, done = 0, hs, drp;
        logic [AW-1:0] ref_addr;
        exp_data.delete();
        // reference walk over the queued packets, from the requirements
        for (int p = 0; p < ep_lens.size() && !done; p++) begin
            int len = ep_lens[p];
            if (cnt == 0) begin e_eob = 1; done = 1; end
            else if (len == 0) begin
                if (eot_en) begin e_eot = 1; done = 1; end
            end else begin
                int n = (len < cnt) ? len : cnt;
                for (int i = 0; i < n; i++) exp_data.push_back(ep_bytes[idx + i]);
                idx += len; left -= n; cnt -= n;
                if (n == len) begin
                    if (ep_sh[p] && eot_en) begin e_eot = 1; done = 1; end
                    if (cnt == 0) begin e_eob = 1; done = 1; end
                end else begin
                    e_eob = 1; done = 1;
                    if (trunc) left -= (len - n);
                end
            end
        end
        if (!done && cnt == 0) e_eob = 1;

        @(negedge clk);
        cfg_addr = base; cfg_size = CW'(size); cfg_eot_en = eot_en; cfg_trunc_en = trunc;
        cfg_eob_irq_en = eobie; cfg_eot_irq_en = eotie; cfg_run = 1'b1;
        @(posedge clk); #1;
        ref_remain = size; ref_addr = base;
        @(negedge clk);
        // R2 busy after start; R8 flags cleared on restart
        check("R2", {tag, " busy after start"}, busy, 1);
        check("R8", {tag, " flags cleared"}, {sts_eob, sts_eot}, 0);
        forever begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            mem_ready = lfsr[0] | lfsr[3];
            #1;
            check("R4", {tag, " remain"}, remain, ref_remain);
            if (!busy) break;
            hs  = mem_valid && mem_ready;
            drp = ep_drop;
            check("R3", {tag, " pop matches handshake"}, ep_pop, hs);
            if (mem_valid) check("R3", {tag, " address"}, mem_addr, ref_addr);
            if (hs) begin
                if (nwr < exp_data.size())
                    check("R3", {tag, " data"}, mem_data, exp_data[nwr]);
                else
                    check("R3", {tag, " extra write"}, nwr, exp_data.size() - 1);
            end
            @(posedge clk); #1;
            if (hs) begin
                void'(ep_bytes.pop_front());
                ep_lens[0]--;
                if (ep_lens[0] == 0) begin void'(ep_lens.pop_front()); void'(ep_sh.pop_front()); end
                ref_addr++; ref_remain--; nwr++;
            end
            if (drp && ep_lens.size() > 0) begin
                for (int i = 0; i < ep_lens[0]; i++) void'(ep_bytes.pop_front());
                void'(ep_lens.pop_front()); void'(ep_sh.pop_front());
            end
            refresh_ep();
            cyc++;
            if (cyc > 3000) begin
                check("R4", {tag, " transfer ended"}, 0, 1);
                break;
            end
            @(negedge clk);
        end
        mem_ready = 1'b0;
        // stays stopped with run still high and packets pending
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check("R8", {tag, " no pop after end"}, ep_pop, 0);
        end
        check("R3", {tag, " bytes written"}, nwr, exp_data.size());
        check("R4", {tag, " eob flag"}, sts_eob, e_eob);
        check("R5", {tag, " eot flag"}, sts_eot, e_eot);
        check("R9", {tag, " irq"}, irq, (e_eob && eobie) || (e_eot && eotie));
        check("R7", {tag, " bytes left in endpoint"}, ep_bytes.size(), left);
        check("R8", {tag, " idle"}, busy, 0);
        cfg_run = 1'b0;
        @(negedge clk); @(negedge clk);
        clear_ep();
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1", "busy", busy, 0);
        check("R1", "mem_valid", mem_valid, 0);
        check("R1", "pop/drop", {ep_pop, ep_drop}, 0);
        check("R1", "flags", {sts_eob, sts_eot}, 0);
        check("R1", "irq", irq, 0);
        check("R1", "remain", remain, 0);

        // R4 R9: full packets fill the buffer exactly
        add_pkt(8, 1); add_pkt(8, 40);
        run_case("full", 32'h1000, 16, 1, 0, 1, 0);
        // R5: short packet ends the transfer
        add_pkt(8, 3); add_pkt(5, 90); add_pkt(8, 20);
        run_case("short", 32'h2000, 40, 1, 0, 0, 1);
        // R5 R7: short packet ignored, tail kept without truncation
        add_pkt(8, 5); add_pkt(5, 60); add_pkt(8, 11); add_pkt(8, 77);
        run_case("keep", 32'h3000, 20, 0, 0, 1, 1);
        // R7 R9: truncation discards the tail, end-of-buffer irq masked
        add_pkt(8, 9); add_pkt(8, 33); add_pkt(8, 55);
        run_case("trunc", 32'h4000, 10, 1, 1, 0, 1);
        // R6: empty packet ends the transfer
        add_pkt(8, 13); add_pkt(0, 0); add_pkt(8, 99);
        run_case("zlp_end", 32'h5000, 20, 1, 0, 0, 1);
        // R6: empty packet skipped without short-packet termination
        add_pkt(0, 0); add_pkt(8, 17);
        run_case("zlp_skip", 32'h6000, 8, 0, 0, 1, 0);
        // R2: zero-size buffer ends at once
        add_pkt(8, 21);
        run_case("zero", 32'h7000, 0, 1, 1, 1, 1);
        // R5: short packet that also fills the buffer
        add_pkt(5, 70); add_pkt(8, 2);
        run_case("both", 32'hFFFF_FFFC, 5, 1, 0, 1, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule